// File: doc/BRIEF.md
# Six-Mode Programmable Timer Channel

This block is a single presettable down-counting timer channel. It is clocked by one system clock. It watches a slow timer clock level (`tclk_i`) and a gate level (`gate_i`), and it drives an output level (`out_o`) according to one of six operating modes:

- terminal-count interrupt
- gate-retriggerable one-shot
- rate generator
- square wave
- software-started strobe
- gate-started strobe

Counting is in plain binary or in four-digit BCD.

A surrounding bus block decodes writes and passes three things to the channel:

- a control-word strobe carrying the mode and number base;
- a strobe with a complete new count;
- a level flag that is high while only the first byte of a two-byte count has arrived.

The channel exposes the live counter value for an outer latch block. It also raises a one-cycle mark each time the count register is copied into the counter.

A timer clock pulse is a rising level followed by a falling level of `tclk_i`. Loads and decrements act on the falling level. Gate level and gate triggers are taken on the rising level. A count of zero stands for the full range: 65536 in binary, 10000 in BCD.

Top module: `prog_timer_chan`

## Requirements
- R1: After synchronous reset, `out_o` is 0, `ce_o` is 0 and `load_o` is 0.
- R2: A control word sets `out_o` on the next system clock, with no timer pulse needed: 0 for mode 0 and 1 for any other mode. The mode is decoded from `cfg_mode_i` as follows: 000 is mode 0, 001 is mode 1, x10 is mode 2, x11 is mode 3, 100 is mode 4 and 101 is mode 5.
- R3: A count written in mode 0 or 4 is copied into the counter on the first timer pulse after the write, and that pulse does not decrement. Each copy raises `load_o` for exactly one system clock. `ce_o` changes only on a timer falling edge.
- R4: In mode 0, `out_o` is low until N+1 pulses after the count write, then high. While the sampled gate is low, the count holds.
- R5: In mode 0, while `cnt_half_i` is high, `out_o` is forced low at once and the count neither loads nor decrements.
- R6: In mode 1, the pulse after a gate trigger loads N and drives `out_o` low. `out_o` goes high when the count reaches 0. A new trigger reloads the count. A count written during the pulse is used only at the next trigger.
- R7: In mode 2, `out_o` is low for the one pulse in which the count is 1, and the next pulse reloads, giving a period of N. A low gate forces `out_o` high on the next system clock. A newly written count is used at the end of the running period.
- R8: In mode 3, an even N gives N/2 pulses high and N/2 pulses low. An odd N gives (N+1)/2 pulses high and (N-1)/2 pulses low. `out_o` toggles and the count reloads when the count expires.
- R9: In mode 3, a low gate forces `out_o` high on the next system clock.
- R10: In mode 4, `out_o` strobes low for one pulse N+1 pulses after the count write. Writing a new count restarts the sequence from the new count.
- R11: In mode 5, `out_o` strobes low for one pulse N+1 pulses after a gate trigger. A new trigger restarts the count.
- R12: A count of 0 acts as the full range. In modes 0, 1, 4 and 5 the counter wraps from 0 to FFFF in binary or 9999 in BCD and keeps counting.
- R13: With `cfg_bcd_i` = 1, every nibble of `ce_o` stays in 0..9. Borrows carry across digits for steps of one, two and three.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tclk_i | input | 1 | Timer clock level, sampled by `clk` |
| gate_i | input | 1 | Gate level, sampled by `clk` |
| cfg_wr_i | input | 1 | Control-word strobe |
| cfg_mode_i | input | 3 | Mode bits of the control word |
| cfg_bcd_i | input | 1 | 1 selects BCD counting |
| cnt_wr_i | input | 1 | Complete new count strobe |
| cnt_val_i | input | CW | New count value |
| cnt_half_i | input | 1 | Only the first byte of a two-byte count is written |
| out_o | output | 1 | Channel output level |
| ce_o | output | CW | Live counter value |
| load_o | output | 1 | One-cycle mark of a count-register-to-counter copy |

## Verification
Gate-low forcing, the first-byte flag and control words show on `out_o` one system clock after the input changes. The bench drives these inputs on a falling `clk` and checks one falling `clk` later.

Counter changes, loads and strobes come from the registered edge of the timer clock. The bench therefore completes each timer pulse (two system clocks high, two low) before it samples. `ce_o` and `out_o` are then read away from every active edge.

Expected counter values are counted in timer pulses from the count write or gate trigger. The first load pulse is included in that count.

// File: rtl/itc_pkg.sv
package itc_pkg;

  typedef enum logic [2:0] {
    M_TERM    = 3'd0,
    M_ONESHOT = 3'd1,
    M_RATE    = 3'd2,
    M_SQUARE  = 3'd3,
    M_SWSTB   = 3'd4,
    M_HWSTB   = 3'd5
  } tmode_e;

  // x1x picks the periodic modes; the top bit is a don't-care there
  function automatic tmode_e decode_mode(input logic [2:0] b);
    tmode_e m;
    if (b[1]) m = b[0] ? M_SQUARE : M_RATE;
    else if (b[2]) m = b[0] ? M_HWSTB : M_SWSTB;
    else m = b[0] ? M_ONESHOT : M_TERM;
    return m;
  endfunction

endpackage

// File: rtl/itc_edge.sv
module itc_edge (
  input  logic clk,
  input  logic rst,
  input  logic tclk_i,
  input  logic gate_i,
  output logic tck_rise,
  output logic tck_fall,
  output logic gate_rise
);
  logic tclk_q, gate_q, hi_seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tclk_q    <= 1'b0;
      gate_q    <= 1'b0;
      hi_seen_q <= 1'b0;
    end else begin
      tclk_q <= tclk_i;
      gate_q <= gate_i;
      if (tck_rise) hi_seen_q <= 1'b1;
      else if (tck_fall) hi_seen_q <= 1'b0;
    end
  end

  assign tck_rise  = tclk_i & ~tclk_q;
  assign tck_fall  = ~tclk_i & tclk_q & hi_seen_q;
  assign gate_rise = gate_i & ~gate_q;
endmodule

// File: rtl/itc_decr.sv
module itc_decr #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  input  logic         bcd,
  input  logic [1:0]   amt,
  output logic [W-1:0] res
);
  localparam int DIG = W / 4;

  logic [W-1:0]   bin_res;
  logic [W-1:0]   bcd_res;
  logic [DIG:0]   borrow;

  assign bin_res   = val - W'(amt);
  assign borrow[0] = 1'b0;

  for (genvar g = 0; g < DIG; g++) begin : g_digit
    logic [4:0] sub;
    logic [4:0] diff;
    if (g == 0) begin : g_low
      assign sub = {3'b000, amt};
    end else begin : g_high
      assign sub = 5'd0;
    end
    assign diff               = {1'b0, val[4*g +: 4]} - sub - {4'b0000, borrow[g]};
    assign borrow[g+1]        = diff[4];
    assign bcd_res[4*g +: 4]  = diff[4] ? (diff[3:0] + 4'd10) : diff[3:0];
  end

  assign res = bcd ? bcd_res : bin_res;

  function automatic logic digits_ok(input logic [W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < DIG; k++) if (v[4*k +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  always_comb begin
    if (bcd && digits_ok(val)) begin
      AST_BCD_RANGE: assert (digits_ok(res)); // R13
    end
  end
endmodule

// File: rtl/prog_timer_chan.sv
module prog_timer_chan
  import itc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tclk_i,
  input  logic          gate_i,
  input  logic          cfg_wr_i,
  input  logic [2:0]    cfg_mode_i,
  input  logic          cfg_bcd_i,
  input  logic          cnt_wr_i,
  input  logic [CW-1:0] cnt_val_i,
  input  logic          cnt_half_i,
  output logic          out_o,
  output logic [CW-1:0] ce_o,
  output logic          load_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic tck_rise, tck_fall, gate_rise;

  itc_edge i_edge (
    .clk       (clk),
    .rst       (rst),
    .tclk_i    (tclk_i),
    .gate_i    (gate_i),
    .tck_rise  (tck_rise),
    .tck_fall  (tck_fall),
    .gate_rise (gate_rise)
  );

  tmode_e        mode_q;
  logic          bcd_q;
  logic [CW-1:0] cr_q, ce_q, dec_res;
  logic          out_q, load_q;
  logic          pend_q, have_q, run_q, armed_q, first_q, odd_q;
  logic          trig_flag_q, trig_s_q, gate_s_q;
  logic [1:0]    amt;
  logic          dec_zero, halt0;

  always_comb begin
    if (mode_q == M_SQUARE) amt = (first_q && odd_q) ? (out_q ? 2'd1 : 2'd3) : 2'd2;
    else                    amt = 2'd1;
  end

  itc_decr #(.W(CW)) i_decr (
    .val (ce_q),
    .bcd (bcd_q),
    .amt (amt),
    .res (dec_res)
  );

  assign dec_zero = (dec_res == '0);
  assign halt0    = (mode_q == M_TERM) && cnt_half_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= M_TERM;
      bcd_q       <= 1'b0;
      cr_q        <= '0;
      ce_q        <= '0;
      out_q       <= 1'b0;
      load_q      <= 1'b0;
      pend_q      <= 1'b0;
      have_q      <= 1'b0;
      run_q       <= 1'b0;
      armed_q     <= 1'b0;
      first_q     <= 1'b0;
      odd_q       <= 1'b0;
      trig_flag_q <= 1'b0;
      trig_s_q    <= 1'b0;
      gate_s_q    <= 1'b0;
    end else begin
      load_q <= 1'b0;
      if (gate_rise) trig_flag_q <= 1'b1;
      if (tck_rise) begin
        gate_s_q    <= gate_i;
        trig_s_q    <= trig_flag_q | gate_rise;
        trig_flag_q <= 1'b0;
      end

      if (tck_fall) begin
        trig_s_q <= 1'b0;
        unique case (mode_q)
          M_TERM, M_SWSTB: begin
            if (mode_q == M_SWSTB && !out_q) out_q <= 1'b1;
            if (pend_q && !halt0) begin
              ce_q    <= cr_q;
              pend_q  <= 1'b0;
              run_q   <= 1'b1;
              armed_q <= 1'b1;
              load_q  <= 1'b1;
            end else if (run_q && gate_s_q && !halt0) begin
              ce_q <= dec_res;
              if (armed_q && dec_zero) begin
                armed_q <= 1'b0;
                out_q   <= (mode_q == M_TERM);
              end
            end
          end
          M_ONESHOT, M_HWSTB: begin
            if (mode_q == M_HWSTB && !out_q) out_q <= 1'b1;
            if (trig_s_q && have_q) begin
              ce_q    <= cr_q;
              run_q   <= 1'b1;
              armed_q <= 1'b1;
              load_q  <= 1'b1;
              if (mode_q == M_ONESHOT) out_q <= 1'b0;
            end else if (run_q) begin
              ce_q <= dec_res;
              if (armed_q && dec_zero) begin
                armed_q <= 1'b0;
                out_q   <= (mode_q == M_ONESHOT);
              end
            end
          end
          M_RATE: begin
            if (((pend_q && !run_q) || trig_s_q) && have_q) begin
              ce_q   <= cr_q;
              run_q  <= 1'b1;
              pend_q <= 1'b0;
              out_q  <= 1'b1;
              load_q <= 1'b1;
            end else if (run_q && gate_s_q) begin
              if (ce_q == ONE) begin
                ce_q   <= cr_q;
                pend_q <= 1'b0;
                out_q  <= 1'b1;
                load_q <= 1'b1;
              end else begin
                ce_q <= dec_res;
                if (dec_res == ONE) out_q <= 1'b0;
              end
            end
          end
          default: begin // M_SQUARE
            if (((pend_q && !run_q) || trig_s_q) && have_q) begin
              ce_q    <= cr_q;
              odd_q   <= cr_q[0];
              first_q <= 1'b1;
              run_q   <= 1'b1;
              pend_q  <= 1'b0;
              out_q   <= 1'b1;
              load_q  <= 1'b1;
            end else if (run_q && gate_s_q) begin
              if (dec_zero) begin
                ce_q    <= cr_q;
                odd_q   <= cr_q[0];
                first_q <= 1'b1;
                pend_q  <= 1'b0;
                out_q   <= ~out_q;
                load_q  <= 1'b1;
              end else begin
                ce_q    <= dec_res;
                first_q <= 1'b0;
              end
            end
          end
        endcase
      end

      if (cnt_wr_i) begin
        cr_q   <= cnt_val_i;
        have_q <= 1'b1;
        pend_q <= 1'b1;
        if (mode_q == M_TERM) out_q <= 1'b0;
      end

      if (halt0) out_q <= 1'b0;
      if ((mode_q == M_RATE || mode_q == M_SQUARE) && !gate_i) out_q <= 1'b1;

      if (cfg_wr_i) begin
        mode_q      <= decode_mode(cfg_mode_i);
        bcd_q       <= cfg_bcd_i;
        out_q       <= (decode_mode(cfg_mode_i) != M_TERM);
        pend_q      <= 1'b0;
        have_q      <= 1'b0;
        run_q       <= 1'b0;
        armed_q     <= 1'b0;
        first_q     <= 1'b0;
        trig_flag_q <= 1'b0;
        trig_s_q    <= 1'b0;
      end
    end
  end

  assign out_o  = out_q;
  assign ce_o   = ce_q;
  assign load_o = load_q;

  AST_CW_OUT_INIT: assert property (@(posedge clk) disable iff (rst)
    cfg_wr_i |=> (out_q == ($past(cfg_mode_i) != 3'b000))); // R2

  AST_LOAD_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    load_q |-> $past(tck_fall)); // R3

  AST_CE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !tck_fall |=> $stable(ce_q)); // R3

  AST_HALF_OUT_LOW: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_TERM && cnt_half_i && !cfg_wr_i) |=> !out_q); // R5

  AST_GATE_FORCE_HIGH: assert property (@(posedge clk) disable iff (rst)
    ((mode_q == M_RATE || mode_q == M_SQUARE) && !gate_i && !cfg_wr_i) |=> out_q); // R7 R9
endmodule

// File: tb/test_prog_timer_chan.sv
module test_prog_timer_chan;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 22;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tclk_i = 1'b0, gate_i = 1'b0;
  logic        cfg_wr_i = 1'b0, cfg_bcd_i = 1'b0;
  logic [2:0]  cfg_mode_i = 3'd0;
  logic        cnt_wr_i = 1'b0, cnt_half_i = 1'b0;
  logic [15:0] cnt_val_i = '0;
  logic        out_o, load_o;
  logic [15:0] ce_o;

  int nchk = 0, nerr = 0, nloads = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_timer_chan #(.CW(16)) i_prog_timer_chan (
    .clk(clk), .rst(rst), .tclk_i(tclk_i), .gate_i(gate_i),
    .cfg_wr_i(cfg_wr_i), .cfg_mode_i(cfg_mode_i), .cfg_bcd_i(cfg_bcd_i),
    .cnt_wr_i(cnt_wr_i), .cnt_val_i(cnt_val_i), .cnt_half_i(cnt_half_i),
    .out_o(out_o), .ce_o(ce_o), .load_o(load_o)
  );

  always @(negedge clk) if (!rst && load_o) nloads++;

  // {mode, bcd, count, pulses, expected ce, expected out, requirement}
  localparam logic [44:0] VEC [NV] = '{
    {3'd0, 1'b0, 16'h0005, 4'd3, 16'h0003, 1'b0, 4'd4},  // R4
    {3'd0, 1'b0, 16'h0005, 4'd5, 16'h0001, 1'b0, 4'd4},  // R4
    {3'd0, 1'b0, 16'h0005, 4'd6, 16'h0000, 1'b1, 4'd4},  // R4
    {3'd0, 1'b0, 16'h0000, 4'd2, 16'hFFFF, 1'b0, 4'd12}, // R12
    {3'd0, 1'b1, 16'h0000, 4'd2, 16'h9999, 1'b0, 4'd12}, // R12
    {3'd0, 1'b1, 16'h0100, 4'd3, 16'h0098, 1'b0, 4'd13}, // R13
    {3'd4, 1'b0, 16'h0003, 4'd4, 16'h0000, 1'b0, 4'd10}, // R10
    {3'd4, 1'b0, 16'h0003, 4'd5, 16'hFFFF, 1'b1, 4'd10}, // R10
    {3'd2, 1'b0, 16'h0003, 4'd3, 16'h0001, 1'b0, 4'd7},  // R7
    {3'd2, 1'b0, 16'h0003, 4'd4, 16'h0003, 1'b1, 4'd7},  // R7
    {3'd2, 1'b0, 16'h0003, 4'd6, 16'h0001, 1'b0, 4'd7},  // R7
    {3'd3, 1'b0, 16'h0004, 4'd3, 16'h0004, 1'b0, 4'd8},  // R8
    {3'd3, 1'b0, 16'h0004, 4'd5, 16'h0004, 1'b1, 4'd8},  // R8
    {3'd3, 1'b0, 16'h0005, 4'd4, 16'h0005, 1'b0, 4'd8},  // R8
    {3'd3, 1'b0, 16'h0005, 4'd5, 16'h0002, 1'b0, 4'd8},  // R8
    {3'd3, 1'b0, 16'h0005, 4'd6, 16'h0005, 1'b1, 4'd8},  // R8
    {3'd3, 1'b1, 16'h0011, 4'd3, 16'h0008, 1'b1, 4'd13}, // R13
    {3'd1, 1'b0, 16'h0003, 4'd2, 16'h0002, 1'b0, 4'd6},  // R6
    {3'd1, 1'b0, 16'h0003, 4'd4, 16'h0000, 1'b1, 4'd6},  // R6
    {3'd5, 1'b0, 16'h0003, 4'd4, 16'h0000, 1'b0, 4'd11}, // R11
    {3'd5, 1'b0, 16'h0003, 4'd5, 16'hFFFF, 1'b1, 4'd12}, // R12
    {3'd2, 1'b1, 16'h0010, 4'd2, 16'h0009, 1'b1, 4'd13}  // R13
  };

  task automatic chk(input int req, input string what, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic sys(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cw(input logic [2:0] m, input logic b);
    cfg_mode_i = m; cfg_bcd_i = b; cfg_wr_i = 1'b1;
    sys(1);
    cfg_wr_i = 1'b0;
  endtask

  task automatic write_cnt(input logic [15:0] v);
    cnt_val_i = v; cnt_wr_i = 1'b1;
    sys(1);
    cnt_wr_i = 1'b0;
  endtask

  task automatic tpulse(input int n);
    for (int k = 0; k < n; k++) begin
      tclk_i = 1'b1; sys(2);
      tclk_i = 1'b0; sys(2);
    end
  endtask

  task automatic retrigger();
    gate_i = 1'b0; sys(1);
    gate_i = 1'b1; sys(1);
  endtask

  task automatic start(input logic [2:0] m, input logic b, input logic [15:0] n);
    gate_i = 1'b0;
    write_cw(m, b);
    write_cnt(n);
    gate_i = 1'b1;
    sys(2);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired (all requirements)");
      summary();
      $finish;
    end
  end

  initial begin
    int l0;
    sys(3);
    rst = 1'b0;
    sys(1);
    // R1 reset state
    chk(1, "reset out", {15'd0, out_o}, 16'd0);
    chk(1, "reset ce", ce_o, 16'd0);
    chk(1, "reset load", {15'd0, load_o}, 16'd0);

    // table of mode, count and pulse vectors
    for (int i = 0; i < NV; i++) begin
      logic [44:0] v;
      v = VEC[i];
      start(v[44:42], v[41], v[40:25]);
      tpulse(int'(v[24:21]));
      chk(int'(v[3:0]), $sformatf("vec %0d ce", i), ce_o, v[20:5]);
      chk(int'(v[3:0]), $sformatf("vec %0d out", i), {15'd0, out_o}, {15'd0, v[4]});
    end

    // R2 control word output state and x1x decode
    write_cw(3'b110, 1'b0);
    chk(2, "cw mode 110 out", {15'd0, out_o}, 16'd1);
    write_cw(3'b000, 1'b0);
    chk(2, "cw mode 000 out", {15'd0, out_o}, 16'd0);
    write_cw(3'b101, 1'b0);
    chk(2, "cw mode 101 out", {15'd0, out_o}, 16'd1);

    // R3 one load on the first pulse, no decrement on it
    start(3'b000, 1'b0, 16'd5);
    l0 = nloads;
    tpulse(1);
    chk(3, "load count after first pulse", 16'(nloads - l0), 16'd1);
    chk(3, "ce after load pulse", ce_o, 16'd5);
    tpulse(1);
    chk(3, "load count after second pulse", 16'(nloads - l0), 16'd1);
    chk(3, "ce after second pulse", ce_o, 16'd4);

    // R4 low gate holds the count
    gate_i = 1'b0; sys(1);
    tpulse(3);
    chk(4, "ce held by low gate", ce_o, 16'd4);
    gate_i = 1'b1; sys(1);
    tpulse(1);
    chk(4, "ce resumes", ce_o, 16'd3);

    // R5 first-byte flag in mode 0
    start(3'b000, 1'b0, 16'd5);
    tpulse(6);
    chk(5, "out high before half", {15'd0, out_o}, 16'd1);
    cnt_half_i = 1'b1; sys(1);
    chk(5, "out low on half flag", {15'd0, out_o}, 16'd0);
    tpulse(2);
    chk(5, "ce frozen by half flag", ce_o, 16'd0);
    cnt_half_i = 1'b0;
    write_cnt(16'd7);
    tpulse(1);
    chk(5, "new count after second byte", ce_o, 16'd7);

    // R6 retrigger extends the one-shot
    start(3'b001, 1'b0, 16'd4);
    tpulse(2);
    chk(6, "one-shot ce", ce_o, 16'd3);
    retrigger();
    tpulse(1);
    chk(6, "retrigger reload", ce_o, 16'd4);
    chk(6, "out low after retrigger", {15'd0, out_o}, 16'd0);
    tpulse(4);
    chk(6, "out high at end", {15'd0, out_o}, 16'd1);
    // R6 count written during pulse waits for a trigger
    start(3'b001, 1'b0, 16'd4);
    tpulse(1);
    write_cnt(16'd9);
    tpulse(1);
    chk(6, "write during pulse ignored", ce_o, 16'd3);
    retrigger();
    tpulse(1);
    chk(6, "new count on trigger", ce_o, 16'd9);

    // R7 gate low forces high; new count at period end
    start(3'b010, 1'b0, 16'd3);
    tpulse(3);
    chk(7, "rate out low", {15'd0, out_o}, 16'd0);
    gate_i = 1'b0; sys(1);
    chk(7, "rate gate-low forces high", {15'd0, out_o}, 16'd1);
    start(3'b110, 1'b0, 16'd3);
    tpulse(1);
    write_cnt(16'd5);
    tpulse(2);
    chk(7, "old period continues", ce_o, 16'd1);
    tpulse(1);
    chk(7, "new count at period end", ce_o, 16'd5);

    // R9 square wave gate low forces high
    start(3'b011, 1'b0, 16'd4);
    tpulse(3);
    chk(9, "square out low", {15'd0, out_o}, 16'd0);
    gate_i = 1'b0; sys(1);
    chk(9, "square gate-low forces high", {15'd0, out_o}, 16'd1);

    // R10 software restart in mode 4
    start(3'b100, 1'b0, 16'd5);
    tpulse(2);
    write_cnt(16'd3);
    tpulse(1);
    chk(10, "mode 4 restart", ce_o, 16'd3);

    // R11 gate restart in mode 5
    start(3'b101, 1'b0, 16'd3);
    tpulse(2);
    chk(11, "mode 5 counting", ce_o, 16'd2);
    retrigger();
    tpulse(1);
    chk(11, "mode 5 restart", ce_o, 16'd3);
    chk(11, "mode 5 out high", {15'd0, out_o}, 16'd1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule